// File: doc/BRIEF.md
# Eight-bit Ripple-Carry Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a small
eight-bit processor. It accepts two operands and a three-bit operation code
and returns a result word, a carry-out bit and a zero flag. The output
follows its inputs within the same cycle. No state is held.

The arithmetic core is a chain of full adders with the carry rippling from
the least significant bit upward. Each full adder is made of two half-adder
stages. The first stage combines the operand bits. The second stage folds in
the incoming carry. The two carry terms can never both be high, so a plain
OR joins them. Subtraction uses the same chain: it inverts the second operand
and forces the carry into bit 0 high. The bitwise AND and XOR results are
the outputs of the first half-adder stage, selected onto the result; no
separate gates produce them. A one-place logical shift in either direction
completes the operation set. Multiply and divide are left to software, which
repeats add or subtract.

Top module: `ripple_alu`

## Requirements
- R1: With opSel = 3'b000 (add), {carryOut, result} equals opA + opB as a 9-bit sum.
- R2: With opSel = 3'b001 (subtract), result equals (opA - opB) mod 256, and carryOut is 1 exactly when opA >= opB (no borrow).
- R3: With opSel = 3'b010 (shift left), result is opA moved up one place with bit 0 filled with 0, and carryOut is the old bit 7 of opA.
- R4: With opSel = 3'b011 (shift right), result is opA moved down one place with bit 7 filled with 0, and carryOut is the old bit 0 of opA.
- R5: With opSel = 3'b100 (AND), result is the bitwise AND of opA and opB, and carryOut is 0.
- R6: With opSel = 3'b101 (XOR), result is the bitwise XOR of opA and opB, and carryOut is 0.
- R7: With opSel = 3'b110 or 3'b111, result is 0 and carryOut is 0, whatever the operands are.
- R8: zero is 1 exactly when all eight result bits are 0, for every operation code.
- R9: A carry generated in bit 0 ripples through all eight bits: 8'hFF + 8'h01 gives result 8'h00, carryOut 1 and zero 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand; the subtrahend for subtract, ignored by the shifts |
| opSel | input | 3 | Operation code |
| result | output | 8 | Selected result word |
| carryOut | output | 1 | Adder carry, no-borrow flag, or the bit shifted out |
| zero | output | 1 | High when result is all zeros |

## Verification
The assertions take the operands and code to be settled two-state values. They compare the ripple chain against a behavioural sum or difference only when every input is known. The bench drives all three inputs together in the half cycle away from the sampling edge, and it never leaves an input undriven once reset is released. So every sampled output belongs to one complete, known input set. The stimulus covers every operation code, including both unused ones. It uses operand pairs that make the carry ripple the full width, that borrow and do not borrow, and that shift a one out of each end.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_SHL = 3'b010,
    OP_SHR = 3'b011,
    OP_AND = 3'b100,
    OP_XOR = 3'b101
  } alu_op_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic invB;     // invert second operand before the adder
    logic carryIn;  // carry into bit 0
    logic selSum;
    logic selShl;
    logic selShr;
    logic selAnd;
    logic selXor;
  } alu_strobe_t;

endpackage

// File: rtl/half_adder.sv
module half_adder (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output alu_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    unique case (opSel)
      OP_ADD: strobe.selSum = 1'b1;
      OP_SUB: begin
        strobe.selSum  = 1'b1;
        strobe.invB    = 1'b1;
        strobe.carryIn = 1'b1;
      end
      OP_SHL: strobe.selShl = 1'b1;
      OP_SHR: strobe.selShr = 1'b1;
      OP_AND: strobe.selAnd = 1'b1;
      OP_XOR: strobe.selXor = 1'b1;
      default: strobe = '0;  // unused codes select nothing
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_strobe_t      strobe,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zero
);
  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] halfSum;   // first-stage XOR, shared by sum and carry
  logic [WIDTH-1:0] halfCarry; // first-stage AND
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH-1:0] midCarry;  // second-stage carry
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] shlBits;
  logic [WIDTH-1:0] shrBits;

  assign bEff     = opB ^ {WIDTH{strobe.invB}};
  assign carry[0] = strobe.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    half_adder u_stage1 (
      .x(opA[i]), .y(bEff[i]), .s(halfSum[i]), .c(halfCarry[i])
    );
    half_adder u_stage2 (
      .x(halfSum[i]), .y(carry[i]), .s(sumBits[i]), .c(midCarry[i])
    );
    // the two carry terms are mutually exclusive, so OR suffices
    assign carry[i+1] = halfCarry[i] | midCarry[i];
  end

  assign shlBits = {opA[WIDTH-2:0], 1'b0};
  assign shrBits = {1'b0, opA[WIDTH-1:1]};

  always_comb begin
    result   = '0;
    carryOut = 1'b0;
    if (strobe.selSum) begin
      result   = sumBits;
      carryOut = carry[WIDTH];
    end else if (strobe.selShl) begin
      result   = shlBits;
      carryOut = opA[WIDTH-1];
    end else if (strobe.selShr) begin
      result   = shrBits;
      carryOut = opA[0];
    end else if (strobe.selAnd) begin
      result   = halfCarry;
    end else if (strobe.selXor) begin
      result   = halfSum;
    end
  end

  assign zero = ~|result;
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zero
);
  alu_strobe_t strobe;

  alu_ctrl u_ctrl (
    .opSel (opSel),
    .strobe(strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .result  (result),
    .carryOut(carryOut),
    .zero    (zero)
  );

  // Cross-checks of the ripple chain and mux against behavioural forms
  logic inputsKnown;
  assign inputsKnown = !$isunknown({opA, opB, opSel});

  always_comb begin
    if (inputsKnown) begin
      if (opSel == OP_ADD)
        p_add_sum_r1: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB}));
      if (opSel == OP_SUB)
        p_sub_diff_r2: assert (result == WIDTH'(opA - opB) && carryOut == (opA >= opB));
      if (opSel == OP_SHL)
        p_shl_out_r3: assert (result[WIDTH-1:1] == opA[WIDTH-2:0] && !result[0]
                              && carryOut == opA[WIDTH-1]);
      if (opSel == OP_SHR)
        p_shr_out_r4: assert (result[WIDTH-2:0] == opA[WIDTH-1:1] && !result[WIDTH-1]
                              && carryOut == opA[0]);
      if (opSel == OP_AND)
        p_and_out_r5: assert (result == (opA & opB) && !carryOut);
      if (opSel == OP_XOR)
        p_xor_out_r6: assert (result == (opA ^ opB) && !carryOut);
      if (opSel[2:1] == 2'b11)
        p_unused_zero_r7: assert (result == '0 && !carryOut && zero);
    end
  end
endmodule

// File: tb/ripple_alu_tb.sv
module ripple_alu_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic [2:0] opSel = 3'b000;
  logic [7:0] result;
  logic carryOut;
  logic zero;

  int total = 0;
  int bad = 0;
  bit driverDone = 0;

  always #5 clk = ~clk;

  ripple_alu u_dut (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .carryOut(carryOut), .zero(zero)
  );

  typedef struct {
    string      tag;
    logic [2:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] res;
    logic       cy;
    logic       zf;
  } item_t;

  item_t sb[$];

  // Reference model built from the requirements R1..R8
  task automatic model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       output logic [7:0] r, output logic c);
    logic [8:0] w;
    case (op)
      3'b000: begin w = {1'b0, a} + {1'b0, b}; r = w[7:0]; c = w[8]; end // R1
      3'b001: begin r = a - b; c = (a >= b); end                        // R2
      3'b010: begin r = {a[6:0], 1'b0}; c = a[7]; end                   // R3
      3'b011: begin r = {1'b0, a[7:1]}; c = a[0]; end                   // R4
      3'b100: begin r = a & b; c = 1'b0; end                            // R5
      3'b101: begin r = a ^ b; c = 1'b0; end                            // R6
      default: begin r = 8'h00; c = 1'b0; end                           // R7
    endcase
  endtask

  task automatic drive(input string tag, input logic [2:0] op,
                       input logic [7:0] a, input logic [7:0] b);
    item_t it;
    logic [7:0] r;
    logic c;
    model(op, a, b, r, c);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    it.tag = tag; it.op = op; it.a = a; it.b = b;
    it.res = r; it.cy = c; it.zf = (r == 8'h00); // R8
    sb.push_back(it);
  endtask

  // Monitor: samples on the rising edge, half a cycle after the drive
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (result !== it.res || carryOut !== it.cy || zero !== it.zf) begin
        bad++;
        $display("FAIL %s op=%b a=%h b=%h actual res=%h c=%b z=%b expected res=%h c=%b z=%b",
                 it.tag, it.op, it.a, it.b, result, carryOut, zero, it.res, it.cy, it.zf);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state: all-zero inputs add to zero with zero flag set (R1, R8)
    drive("R8", 3'b000, 8'h00, 8'h00);
    // R1: addition
    drive("R1", 3'b000, 8'hB4, 8'h8C);
    drive("R1", 3'b000, 8'h0B, 8'h03);
    drive("R1", 3'b000, 8'h7F, 8'h7F);
    // R9: full-width ripple
    drive("R9", 3'b000, 8'hFF, 8'h01);
    drive("R9", 3'b000, 8'h80, 8'h80);
    // R2: subtraction, borrow and no borrow, equal operands
    drive("R2", 3'b001, 8'h50, 8'h20);
    drive("R2", 3'b001, 8'h20, 8'h50);
    drive("R2", 3'b001, 8'h3C, 8'h3C);
    drive("R2", 3'b001, 8'h00, 8'hFF);
    // R3 / R4: shifts with and without a bit lost off the end
    drive("R3", 3'b010, 8'h81, 8'hFF);
    drive("R3", 3'b010, 8'h40, 8'h00);
    drive("R3", 3'b010, 8'h80, 8'h12);
    drive("R4", 3'b011, 8'h81, 8'hFF);
    drive("R4", 3'b011, 8'h02, 8'h00);
    drive("R4", 3'b011, 8'h01, 8'h34);
    // R5 / R6: bitwise
    drive("R5", 3'b100, 8'hF0, 8'h3C);
    drive("R5", 3'b100, 8'hAA, 8'h55);
    drive("R6", 3'b101, 8'hF0, 8'h3C);
    drive("R6", 3'b101, 8'h5A, 8'h5A);
    // R7: unused codes
    drive("R7", 3'b110, 8'hFF, 8'hFF);
    drive("R7", 3'b111, 8'h12, 8'h34);
    // sweep every code over a spread of operand pairs
    for (int k = 0; k < 48; k++) begin
      logic [7:0] a;
      logic [7:0] b;
      a = 8'(k * 37 + 5);
      b = 8'(k * 91 + 200);
      for (int op = 0; op < 8; op++) begin
        drive((op == 0) ? "R1" : (op == 1) ? "R2" : (op == 2) ? "R3" :
              (op == 3) ? "R4" : (op == 4) ? "R5" : (op == 5) ? "R6" : "R7",
              3'(op), a, b);
      end
    end
    @(negedge clk);
    @(negedge clk);
    driverDone = 1;
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!driverDone && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    #1;
    if (!driverDone) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule